// File: doc/BRIEF.md
# Bit-Serial Depth Compositing Node

This block is one node in a daisy chain of compositors that merges partial images into one final image. It receives two pixel streams on narrow serial lanes. The upstream stream comes from the previous node in the chain. The local stream comes from this node's own pixel memory. Each pixel travels as a record: a depth field first, then a colour/attribute payload. A start-of-pixel strobe marks the first beat of each record. In compositing mode, the node compares the two depth fields while the bits arrive, most significant bit first. It then forwards the whole record of the nearer pixel, and it never needs to hold a full record before deciding.

The same serial datapath has three more modes. In load mode, the upstream record is captured into a local buffer so it can be written to pixel memory. In unload mode, the local stream goes out onto the chain. In bypass mode, the upstream data is repeated unchanged, so a node whose memory is busy can be skipped. The mode is picked per record and is fixed for the whole record. The output is registered, so it appears one cycle after the beat that produced it.

The record is `ZW + PW` bits long. That length must be a whole multiple of the lane count. One record therefore takes `(ZW+PW)/LANES` beats.

Top module: `zpix_compositor`

## Requirements
- R1: Record bits are numbered 0 (first sent, the depth MSB) to ZW+PW-1. Bits 0..ZW-1 are depth, MSB first, and the rest are payload. On beat b of a record (b = 0 on the cycle `sop_i` is high), lane i carries record bit LANES*b+i. `out_o` and `out_sop_o` reproduce the chosen beat and its strobe exactly one clock later.
- R2: In compositing mode (`mode_i` = 2'b00), the forwarded record is the complete record (depth and payload) of the side whose depth, read as an unsigned number, is smaller.
- R3: The decision is made bit by bit. Before the first depth bit where the two sides differ, the output carries their common bits. At that bit, the side holding 0 wins, and the choice stays fixed until the record ends.
- R4: When both depth fields are equal, the upstream record is forwarded.
- R5: In load mode (2'b01), `out_o` stays all zero during the record. The upstream record is shifted into the capture buffer. `cap_valid_o` pulses for one cycle, on the clock after the last beat, and `cap_rec_o` then holds the record with bit 0 at its MSB.
- R6: In unload mode (2'b10), the output is the local stream, unchanged.
- R7: In bypass mode (2'b11), the output is the upstream stream, unchanged.
- R8: `mode_i` is sampled only on the beat where `sop_i` is high. A change during a record has no effect until the next start-of-pixel.
- R9: Between records (no record active), `out_o` is all zero, `out_sop_o` is low and `cap_valid_o` stays low.
- R10: After reset, `out_o` is zero and both `out_sop_o` and `cap_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop_i | input | 1 | High on the first beat of a record |
| mode_i | input | 2 | Mode request, sampled with `sop_i` |
| up_i | input | LANES | Upstream chain lanes |
| loc_i | input | LANES | Local pixel-memory lanes |
| out_o | output | LANES | Downstream chain lanes, registered |
| out_sop_o | output | 1 | Start-of-pixel, delayed with the data |
| cap_rec_o | output | ZW+PW | Last record captured in load mode |
| cap_valid_o | output | 1 | One-cycle pulse when `cap_rec_o` is new |

## Verification
The assertions assume that both streams share one framing. A start-of-pixel may come only on the first cycle, or once the previous record's last beat has passed. Each record is sent as consecutive beats with no gaps. The bench meets this by driving every record through a single task. That task raises the strobe on beat zero only, and it allows idle cycles only between whole records. The sweep uses a reduced configuration: an 8-bit depth and a 4-bit payload. It pairs every upstream depth with the equal value, with each single-bit flip, and with nearby and scattered values, in all four modes.

// File: rtl/zcomp_pkg.sv
package zcomp_pkg;

  typedef enum logic [1:0] {
    M_COMP   = 2'b00,
    M_LOAD   = 2'b01,
    M_UNLOAD = 2'b10,
    M_BYPASS = 2'b11
  } zmode_e;

  typedef struct packed {
    logic bit_o;
    logic dec;
    logic loc;
  } step_t;

  // True when lane `lane` of beat `beat` carries a depth bit.
  function automatic logic zbit_en(input int unsigned beat, input int unsigned lane,
                                   input int unsigned lanes, input int unsigned zw);
    return (beat * lanes + lane) < zw;
  endfunction

  // One MSB-first compare step: settle the winner on the first differing
  // depth bit (side with 0 wins), then steer the bit from the latched side.
  function automatic step_t cmp_step(input logic dec, input logic loc, input logic zbit,
                                     input logic a_up, input logic a_loc);
    step_t r;
    r.dec = dec;
    r.loc = loc;
    if (!dec && zbit && (a_up != a_loc)) begin
      r.dec = 1'b1;
      r.loc = a_up;
    end
    r.bit_o = (r.dec && r.loc) ? a_loc : a_up;
    return r;
  endfunction

endpackage

// File: rtl/zc_framer.sv
module zc_framer #(
  parameter int unsigned BEATS = 14,
  localparam int unsigned CW = $clog2(BEATS) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sop,
  input  zcomp_pkg::zmode_e     mode_req,
  output logic [CW-1:0]         beat,
  output logic                  active,
  output logic                  last,
  output zcomp_pkg::zmode_e     mode_act
);
  logic [CW-1:0]     cnt_q;
  logic              act_q;
  zcomp_pkg::zmode_e mode_q;

  assign beat     = sop ? '0 : cnt_q;
  assign active   = sop | act_q;
  assign last     = active && (beat == CW'(BEATS - 1));
  assign mode_act = sop ? mode_req : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      mode_q <= zcomp_pkg::M_COMP;
    end else begin
      if (sop) mode_q <= mode_req;
      if (active) begin
        cnt_q <= beat + 1'b1;
        act_q <= !last;
      end
    end
  end

  // R1: a running record always sits on a beat inside the record
  a_r1_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0 && cnt_q < CW'(BEATS)));

endmodule

// File: rtl/zc_serial_cmp.sv
module zc_serial_cmp #(
  parameter int unsigned LANES = 4,
  parameter int unsigned ZW    = 24,
  parameter int unsigned CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             active,
  input  logic [CW-1:0]    beat,
  input  logic [LANES-1:0] up,
  input  logic [LANES-1:0] loc,
  output logic [LANES-1:0] sel_bits,
  output logic             dec_n
);
  import zcomp_pkg::*;

  logic dec_q, loc_q, loc_n;

  always_comb begin
    logic  d, w;
    step_t st;
    d = sop ? 1'b0 : dec_q;
    w = sop ? 1'b0 : loc_q;
    for (int i = 0; i < LANES; i++) begin
      st          = cmp_step(d, w, zbit_en(32'(beat), i, LANES, ZW), up[i], loc[i]);
      sel_bits[i] = st.bit_o;
      d           = st.dec;
      w           = st.loc;
    end
    dec_n = d;
    loc_n = w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= 1'b0;
      loc_q <= 1'b0;
    end else if (active) begin
      dec_q <= dec_n;
      loc_q <= loc_n;
    end
  end

  // R3: once settled, the winner stays fixed for the rest of the record
  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sop && dec_q) |=> (dec_q && loc_q == $past(loc_q)));

  // R4: while no depth bit has differed, the upstream bits go out
  a_r4_tie_upstream: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dec_n) |-> (sel_bits == up));

endmodule

// File: rtl/zc_capture.sv
module zc_capture #(
  parameter int unsigned LANES = 4,
  parameter int unsigned RW    = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             last,
  input  logic [LANES-1:0] up,
  output logic [RW-1:0]    cap_rec,
  output logic             cap_valid
);
  logic [LANES-1:0] beat_msb;

  // lane 0 holds the earliest bit of the beat, so it lands most significant
  for (genvar i = 0; i < LANES; i++) begin : g_order
    assign beat_msb[LANES-1-i] = up[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rec   <= '0;
      cap_valid <= 1'b0;
    end else begin
      if (en) cap_rec <= {cap_rec[RW-LANES-1:0], beat_msb};
      cap_valid <= en && last;
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> !cap_valid);

endmodule

// File: rtl/zpix_compositor.sv
module zpix_compositor #(
  parameter int unsigned ZW    = 24,
  parameter int unsigned PW    = 32,
  parameter int unsigned LANES = 4,
  localparam int unsigned RW    = ZW + PW,
  localparam int unsigned BEATS = RW / LANES,
  localparam int unsigned CW    = $clog2(BEATS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop_i,
  input  logic [1:0]       mode_i,
  input  logic [LANES-1:0] up_i,
  input  logic [LANES-1:0] loc_i,
  output logic [LANES-1:0] out_o,
  output logic             out_sop_o,
  output logic [RW-1:0]    cap_rec_o,
  output logic             cap_valid_o
);
  import zcomp_pkg::*;

  logic [CW-1:0]    beat;
  logic             active, last, dec_n;
  zmode_e           mode_act;
  logic [LANES-1:0] sel_bits, out_n;

  zc_framer #(.BEATS(BEATS)) u_framer (
    .clk(clk), .rst_n(rst_n), .sop(sop_i), .mode_req(zmode_e'(mode_i)),
    .beat(beat), .active(active), .last(last), .mode_act(mode_act)
  );

  zc_serial_cmp #(.LANES(LANES), .ZW(ZW), .CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .sop(sop_i), .active(active), .beat(beat),
    .up(up_i), .loc(loc_i), .sel_bits(sel_bits), .dec_n(dec_n)
  );

  zc_capture #(.LANES(LANES), .RW(RW)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(active && mode_act == M_LOAD), .last(last),
    .up(up_i), .cap_rec(cap_rec_o), .cap_valid(cap_valid_o)
  );

  always_comb begin
    out_n = '0;
    if (active) begin
      unique case (mode_act)
        M_COMP:   out_n = sel_bits;
        M_LOAD:   out_n = '0;
        M_UNLOAD: out_n = loc_i;
        M_BYPASS: out_n = up_i;
        default:  out_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_o     <= '0;
      out_sop_o <= 1'b0;
    end else begin
      out_o     <= out_n;
      out_sop_o <= sop_i;
    end
  end

  // R8: the mode in force never changes inside a record
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sop_i) |-> (mode_act == $past(mode_act)));

  // R7: bypass repeats the upstream lanes one clock later
  a_r7_bypass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_act == M_BYPASS) |=> (out_o == $past(up_i)));

  // R6: unload repeats the local lanes one clock later
  a_r6_unload_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_act == M_UNLOAD) |=> (out_o == $past(loc_i)));

  // R9: no record means a quiet output
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (out_o == '0 && !out_sop_o));

  // R5: loading keeps the chain output quiet
  a_r5_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode_act == M_LOAD) |=> (out_o == '0));

endmodule

// File: tb/test_zpix_compositor.sv
module test_zpix_compositor;
  localparam int ZW = 8, PW = 4, L = 4;
  localparam int RW = ZW + PW, BE = RW / L;

  logic clk = 1'b0, rst_n = 1'b0, sop = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [L-1:0] up = '0, loc = '0;
  logic [L-1:0] out_o;
  logic out_sop_o, cap_valid_o;
  logic [RW-1:0] cap_rec_o;

  int n_chk = 0, n_fail = 0;
  logic pv = 1'b0, psop = 1'b0, pcap = 1'b0;
  logic [L-1:0] pexp = '0;
  logic [RW-1:0] pcexp = '0;
  string ptag = "";

  always #5 clk = ~clk;

  zpix_compositor #(.ZW(ZW), .PW(PW), .LANES(L)) i_zpix_compositor (
    .clk(clk), .rst_n(rst_n), .sop_i(sop), .mode_i(mode), .up_i(up), .loc_i(loc),
    .out_o(out_o), .out_sop_o(out_sop_o), .cap_rec_o(cap_rec_o), .cap_valid_o(cap_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [RW-1:0] act,
                     input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [L-1:0] lanes(input logic [RW-1:0] rec, input int b);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) r[i] = rec[RW-1-(b*L+i)];
    return r;
  endfunction

  // One beat: check what the previous beat produced, then drive this one.
  task automatic tick(input logic s, input logic [1:0] m, input logic [L-1:0] u,
                      input logic [L-1:0] lc, input logic [L-1:0] e, input string tag,
                      input logic cx, input logic [RW-1:0] cexp);
    @(negedge clk);
    if (pv) begin
      chk(out_o == pexp, ptag, RW'(out_o), RW'(pexp));
      chk(out_sop_o == psop, "R1 strobe", RW'(out_sop_o), RW'(psop));
      chk(cap_valid_o == pcap, "R5 pulse", RW'(cap_valid_o), RW'(pcap));
      if (pcap) chk(cap_rec_o == pcexp, "R5 record", cap_rec_o, pcexp);
    end
    sop = s; mode = m; up = u; loc = lc;
    pv = 1'b1; pexp = e; psop = s; ptag = tag; pcap = cx; pcexp = cexp;
  endtask

  task automatic send_rec(input logic [1:0] m0, input logic [1:0] m1,
                          input logic [RW-1:0] ru, input logic [RW-1:0] rl, input string mtag);
    logic [RW-1:0] er;
    string tag;
    logic [ZW-1:0] zu, zl;
    zu = ru[RW-1 -: ZW];
    zl = rl[RW-1 -: ZW];
    case (m0)
      2'b00:   er = (zl < zu) ? rl : ru;
      2'b01:   er = '0;
      2'b10:   er = rl;
      default: er = ru;
    endcase
    for (int b = 0; b < BE; b++) begin
      if (mtag != "") tag = mtag;
      else if (m0 == 2'b00 && zu == zl) tag = "R4 tie";
      else if (m0 == 2'b00 && b * L < ZW) tag = "R3 depth beat";
      else if (m0 == 2'b00) tag = "R2 payload beat";
      else if (m0 == 2'b01) tag = "R5 quiet";
      else if (m0 == 2'b10) tag = "R6 unload";
      else tag = "R7 bypass";
      tick(b == 0, (b == 0) ? m0 : m1, lanes(ru, b), lanes(rl, b), lanes(er, b), tag,
           (m0 == 2'b01) && (b == BE - 1), ru);
    end
  endtask

  task automatic idle(input logic [L-1:0] junk);
    tick(1'b0, 2'b11, junk, ~junk, '0, "R9 idle", 1'b0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [ZW-1:0] zl;
    logic [PW-1:0] pu, pl;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_o == '0, "R10 out", RW'(out_o), '0);
    chk(out_sop_o == 1'b0, "R10 strobe", RW'(out_sop_o), '0);
    chk(cap_valid_o == 1'b0, "R10 pulse", RW'(cap_valid_o), '0);
    rst_n = 1'b1;
    idle(4'hA);
    for (int zu = 0; zu < 256; zu++) begin
      for (int k = 0; k < 11; k++) begin
        if (k == 0) zl = ZW'(zu);
        else if (k < 9) zl = ZW'(zu) ^ ZW'(1 << (k - 1));
        else if (k == 9) zl = ZW'(zu + 1);
        else zl = ZW'(zu * 37 + 11);
        pu = PW'(zu * 7 + k);
        pl = ~PW'(zu * 3 + k * 5);
        send_rec(2'(k % 4), 2'(k % 4), {ZW'(zu), pu}, {zl, pl}, "");
        if ((zu + k) % 13 == 0) idle(4'(zu));
      end
    end
    // R8: a mid-record mode request is ignored
    send_rec(2'b10, 2'b11, 12'h5A3, 12'hC3F, "R8 unload held");
    send_rec(2'b00, 2'b01, 12'h80F, 12'h7F0, "R8 compare held");
    send_rec(2'b11, 2'b10, 12'h123, 12'hFED, "R8 bypass held");
    // R1: back-to-back records after a gap, checked per lane position
    idle(4'hF);
    send_rec(2'b11, 2'b11, 12'b1000_0100_0010, 12'h000, "R1 lane order");
    send_rec(2'b01, 2'b01, 12'h9C6, 12'h000, "");
    idle(4'h5);
    idle(4'h5);
    @(negedge clk);
    chk(out_o == pexp, ptag, RW'(out_o), RW'(pexp));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule